// File: doc/BRIEF.md
# Effective Address Generator

This block turns the instruction word into the address that the rest of the processor uses for a data access or a change of control flow. It looks at the opcode, takes the instruction's offset field of the right width, sign-extends it, and adds it either to the PC or to the value of the base register. The PC it receives is already incremented. A register-direct jump passes the base register value through unchanged. Address sums wrap modulo 65,536 and no overflow is reported. No mode forms an absolute address from the instruction alone.

Indirect loads and stores need two steps. In the first step the block presents the PC-relative address of a pointer word. When the surrounding sequencer raises the capture strobe, the word on the read-data bus is stored together with the instruction that asked for it. From then on, for as long as that same instruction word is on the input, the stored pointer is the output address. When and how memory is read is up to the sequencer.

The output is purely combinational from the inputs and the pointer register. The pointer register changes only on a clock edge.

Top module: `eff_addr_gen`

## Requirements
- R1: For opcodes BR (IR[15:12]=0000), LD (0010), ST (0011) and LEA (1110), addr_o equals pc_i plus IR[8:0] sign-extended, and mode_o is 1 (PC-relative).
- R2: For opcodes LDR (0110) and STR (0111), addr_o equals base_i plus IR[5:0] sign-extended, and mode_o is 2 (base plus offset).
- R3: For opcode JMP (1100) with IR[11:9] and IR[5:0] all zero, addr_o equals base_i and mode_o is 3 (register jump). A JMP word with any of those bits set gives mode_o 0 and addr_o 0.
- R4: Every other opcode (for example 0001, 0101, 1001, 1111) gives mode_o 0 and addr_o 0.
- R5: For LDI (1010) and STI (1011), when no pointer has been captured for the present instruction word, addr_o is the PC-relative address of R1 and mode_o is 4 (pointer fetch).
- R6: A clock edge with capture_i high while an LDI or STI word is on ir_i stores rdata_i. From the next cycle on, while ir_i holds that same word, addr_o equals the stored word and mode_o is 5 (final indirect).
- R7: The capture strobe has no effect while a non-indirect opcode is on ir_i. Without the strobe, the stored pointer holds its value whatever rdata_i does.
- R8: A stored pointer belongs to the exact instruction word that captured it. Any other LDI or STI word gets mode 4, and the pointer is seen again when the original word comes back.
- R9: All address sums wrap modulo 2^16, across xFFFF in both directions, and no flag is raised.
- R10: A clock edge with rst_n low (synchronous, active low) discards any stored pointer, so the next indirect word gives mode 4.
- R11: The extreme offsets +255 and -256 on the 9-bit field, and +31 and -32 on the 6-bit field, give exact sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_i | input | 16 | Instruction word being executed |
| pc_i | input | 16 | Already-incremented program counter |
| base_i | input | 16 | Value of the register selected by IR[8:6] |
| rdata_i | input | 16 | Memory read data carrying the pointer word |
| capture_i | input | 1 | Strobe that stores rdata_i as the pointer for an indirect instruction |
| addr_o | output | 16 | Effective address |
| mode_o | output | 3 | Address kind: 0 none, 1 PC-relative, 2 base+offset, 3 register jump, 4 pointer fetch, 5 final indirect |

## Verification
The hardest case to reach from the ports is a stored pointer that has to survive while the IR changes. The pointer must stay intact through a strobe on a non-indirect word and through a different indirect word. It must then come back when the original word returns. The stimulus captures a pointer for one LDI word and strobes capture with new data during an LD. It then switches to a different LDI offset and finally returns to the first word, comparing address and mode against a behavioural model on every cycle. Reset is applied after a capture to show that the stored pointer is dropped.

// File: rtl/eag_pkg.sv
// Package: shared opcode values, address-kind tag and decode control
// record for the effective address generator.
// Assumes 16-bit instruction words with the opcode in the top 4 bits.
package eag_pkg;

    localparam int EA_AW    = 16;
    localparam int EA_OPC_W = 4;

    localparam logic [EA_OPC_W-1:0] OPC_BR  = 4'b0000;
    localparam logic [EA_OPC_W-1:0] OPC_LD  = 4'b0010;
    localparam logic [EA_OPC_W-1:0] OPC_ST  = 4'b0011;
    localparam logic [EA_OPC_W-1:0] OPC_LDR = 4'b0110;
    localparam logic [EA_OPC_W-1:0] OPC_STR = 4'b0111;
    localparam logic [EA_OPC_W-1:0] OPC_LDI = 4'b1010;
    localparam logic [EA_OPC_W-1:0] OPC_STI = 4'b1011;
    localparam logic [EA_OPC_W-1:0] OPC_JMP = 4'b1100;
    localparam logic [EA_OPC_W-1:0] OPC_LEA = 4'b1110;

    // Address kind reported on mode_o
    typedef enum logic [2:0] {
        EA_NONE      = 3'd0,
        EA_PCREL     = 3'd1,
        EA_BASEOFF   = 3'd2,
        EA_REGJMP    = 3'd3,
        EA_IND_PTR   = 3'd4,
        EA_IND_FINAL = 3'd5
    } ea_mode_e;

    // Which operand pair forms the address
    typedef enum logic [1:0] {
        SRC_ZERO  = 2'd0,
        SRC_PCOFF = 2'd1,
        SRC_BOFF  = 2'd2,
        SRC_BASE  = 2'd3
    } ea_src_e;

    typedef struct packed {
        ea_src_e src;
        logic    indirect;
    } ea_ctl_t;

endpackage

// File: rtl/eag_decode.sv
// Module: eag_decode
// Maps the opcode field of the instruction to an address source and an
// indirect flag. A register jump is only accepted when its reserved
// fields are zero; otherwise the word yields no address.
// Assumes the opcode occupies the top OPC_W bits of the instruction.
module eag_decode
    import eag_pkg::*;
#(
    parameter int AW      = 16,
    parameter int OPC_W   = 4,
    parameter int PCOFF_W = 9,
    parameter int BOFF_W  = 6
) (
    input  logic [AW-1:0] ir,
    output ea_ctl_t       ctl
);

    localparam int OPC_LSB  = AW - OPC_W;
    localparam int BREG_LSB = BOFF_W;
    localparam int BREG_W   = PCOFF_W - BOFF_W;
    localparam int DR_LSB   = PCOFF_W;
    localparam int DR_W     = OPC_LSB - PCOFF_W;

    logic [OPC_W-1:0] opc;
    logic             jmp_ok;

    assign opc    = ir[OPC_LSB +: OPC_W];
    assign jmp_ok = (ir[DR_LSB +: DR_W] == '0) && (ir[0 +: BOFF_W] == '0);

    // Purpose: choose the address source from the opcode
    always_comb begin
        ctl.src      = SRC_ZERO;
        ctl.indirect = 1'b0;
        unique case (opc)
            OPC_BR, OPC_LD, OPC_ST, OPC_LEA: ctl.src = SRC_PCOFF;
            OPC_LDI, OPC_STI: begin
                ctl.src      = SRC_PCOFF;
                ctl.indirect = 1'b1;
            end
            OPC_LDR, OPC_STR: ctl.src = SRC_BOFF;
            OPC_JMP:          ctl.src = jmp_ok ? SRC_BASE : SRC_ZERO;
            default:          ctl.src = SRC_ZERO;
        endcase
    end

    logic unused_breg;
    assign unused_breg = ^ir[BREG_LSB +: BREG_W];

endmodule

// File: rtl/eag_offset_add.sv
// Module: eag_offset_add
// Sign-extends an OFF_W-bit offset to AW bits and adds it to a base.
// The sum is truncated to AW bits, so it wraps modulo 2^AW.
module eag_offset_add #(
    parameter int AW    = 16,
    parameter int OFF_W = 9
) (
    input  logic [AW-1:0]    base,
    input  logic [OFF_W-1:0] off,
    output logic [AW-1:0]    sum
);

    localparam int EXT_W = AW - OFF_W;

    logic [AW-1:0] off_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
        end else begin : g_noext
            assign off_ext = off[AW-1:0];
        end
    endgenerate

    // Purpose: modular add of base and extended offset
    assign sum = base + off_ext;

endmodule

// File: rtl/eag_ptr_reg.sv
// Module: eag_ptr_reg
// Holds the pointer word read for an indirect instruction, together with
// the instruction word that captured it and a valid bit. It loads only
// when load_en is high and otherwise keeps all its state.
// Assumes reset is synchronous and active low.
module eag_ptr_reg #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [AW-1:0] rdata,
    input  logic [AW-1:0] ir,
    output logic [AW-1:0] ptr_word,
    output logic [AW-1:0] ptr_ir,
    output logic          ptr_valid
);

    // Purpose: capture pointer and owning instruction on strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_word  <= '0;
            ptr_ir    <= '0;
            ptr_valid <= 1'b0;
        end else if (load_en) begin
            ptr_word  <= rdata;
            ptr_ir    <= ir;
            ptr_valid <= 1'b1;
        end
    end

endmodule

// File: rtl/eff_addr_gen.sv
// Module: eff_addr_gen (top)
// Forms the effective address for PC-relative, base-plus-offset,
// register-jump and two-step indirect instructions, and reports the kind
// of address on mode_o. Address outputs are combinational from the
// inputs and from the pointer register.
// Assumes pc_i is already incremented and base_i is the register chosen
// by the instruction's base field.
module eff_addr_gen
    import eag_pkg::*;
#(
    parameter int AW      = EA_AW,
    parameter int OPC_W   = EA_OPC_W,
    parameter int PCOFF_W = 9,
    parameter int BOFF_W  = 6,
    parameter int MODE_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     ir_i,
    input  logic [AW-1:0]     pc_i,
    input  logic [AW-1:0]     base_i,
    input  logic [AW-1:0]     rdata_i,
    input  logic              capture_i,
    output logic [AW-1:0]     addr_o,
    output logic [MODE_W-1:0] mode_o
);

    ea_ctl_t       ctl;
    logic [AW-1:0] pc_sum;
    logic [AW-1:0] base_sum;
    logic [AW-1:0] ptr_word;
    logic [AW-1:0] ptr_ir;
    logic          ptr_valid;
    logic          ptr_hit;
    ea_mode_e      mode_d;

    eag_decode #(
        .AW      (AW),
        .OPC_W   (OPC_W),
        .PCOFF_W (PCOFF_W),
        .BOFF_W  (BOFF_W)
    ) u_dec (
        .ir  (ir_i),
        .ctl (ctl)
    );

    eag_offset_add #(.AW(AW), .OFF_W(PCOFF_W)) u_pc_add (
        .base (pc_i),
        .off  (ir_i[PCOFF_W-1:0]),
        .sum  (pc_sum)
    );

    eag_offset_add #(.AW(AW), .OFF_W(BOFF_W)) u_base_add (
        .base (base_i),
        .off  (ir_i[BOFF_W-1:0]),
        .sum  (base_sum)
    );

    eag_ptr_reg #(.AW(AW)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (capture_i & ctl.indirect),
        .rdata     (rdata_i),
        .ir        (ir_i),
        .ptr_word  (ptr_word),
        .ptr_ir    (ptr_ir),
        .ptr_valid (ptr_valid)
    );

    // Purpose: pointer applies only to the instruction that captured it
    assign ptr_hit = ptr_valid & ctl.indirect & (ptr_ir == ir_i);

    // Purpose: select the final address and its kind tag
    always_comb begin
        addr_o = '0;
        mode_d = EA_NONE;
        unique case (ctl.src)
            SRC_PCOFF: begin
                if (ptr_hit) begin
                    addr_o = ptr_word;
                    mode_d = EA_IND_FINAL;
                end else begin
                    addr_o = pc_sum;
                    mode_d = ctl.indirect ? EA_IND_PTR : EA_PCREL;
                end
            end
            SRC_BOFF: begin
                addr_o = base_sum;
                mode_d = EA_BASEOFF;
            end
            SRC_BASE: begin
                addr_o = base_i;
                mode_d = EA_REGJMP;
            end
            default: begin
                addr_o = '0;
                mode_d = EA_NONE;
            end
        endcase
    end

    assign mode_o = MODE_W'(mode_d);

endmodule

// File: rtl/eag_chk.sv
// Module: eag_chk
// Property checker for eff_addr_gen, attached with bind below.
module eag_chk #(
    parameter int AW     = 16,
    parameter int MODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     ir_i,
    input logic [AW-1:0]     base_i,
    input logic [AW-1:0]     rdata_i,
    input logic              capture_i,
    input logic [AW-1:0]     addr_o,
    input logic [MODE_W-1:0] mode_o,
    input logic [AW-1:0]     ptr_word
);

    // R3
    reg_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd3) |-> (addr_o == base_i && ir_i[11:9] == 3'd0 && ir_i[5:0] == 6'd0));

    // R4
    no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0) |-> (addr_o == '0));

    // R6
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_i && (mode_o == 3'd4 || mode_o == 3'd5)) |=> (ptr_word == $past(rdata_i)));

    // R6
    final_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd5) |-> (addr_o == ptr_word));

    // R7
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> $stable(ptr_word));

    // R7
    ign_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_i && mode_o != 3'd4 && mode_o != 3'd5) |=> $stable(ptr_word));

endmodule

bind eff_addr_gen eag_chk #(.AW(AW), .MODE_W(MODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ir_i      (ir_i),
    .base_i    (base_i),
    .rdata_i   (rdata_i),
    .capture_i (capture_i),
    .addr_o    (addr_o),
    .mode_o    (mode_o),
    .ptr_word  (ptr_word)
);

// File: tb/eff_addr_gen_tb.sv
module eff_addr_gen_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ir = '0, pc = '0, base = '0, rdata = '0;
    logic        cap = 1'b0;
    logic [15:0] addr;
    logic [2:0]  mode;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // behavioural model state
    logic [15:0] m_ptr = '0, m_ir = '0;
    bit          m_val = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eff_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .ir_i(ir), .pc_i(pc), .base_i(base),
        .rdata_i(rdata), .capture_i(cap), .addr_o(addr), .mode_o(mode)
    );

    function automatic bit is_ind(logic [15:0] w);
        return (w[15:12] == 4'd10) || (w[15:12] == 4'd11);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_val <= 0; m_ptr <= '0; m_ir <= '0;
        end else if (cap && is_ind(ir)) begin
            m_val <= 1; m_ptr <= rdata; m_ir <= ir;
        end
    end

    function automatic logic [18:0] model(logic [15:0] w, logic [15:0] p, logic [15:0] b);
        int o9 = w[8] ? int'(w[8:0]) - 512 : int'(w[8:0]);
        int o6 = w[5] ? int'(w[5:0]) - 64 : int'(w[5:0]);
        logic [15:0] pcrel = 16'(int'(p) + o9);
        logic [15:0] brel  = 16'(int'(b) + o6);
        case (int'(w[15:12]))
            0, 2, 3, 14: return {3'd1, pcrel};
            10, 11:      return (m_val && m_ir == w) ? {3'd5, m_ptr} : {3'd4, pcrel};
            6, 7:        return {3'd2, brel};
            12:          return (w[11:9] == 0 && w[5:0] == 0) ? {3'd3, b} : 19'd0;
            default:     return 19'd0;
        endcase
    endfunction

    function automatic logic [15:0] i9(int op, int off);
        return {4'(op), 3'd1, 9'(off)};
    endfunction

    function automatic logic [15:0] i6(int op, int off);
        return {4'(op), 3'd2, 3'd5, 6'(off)};
    endfunction

    task automatic step(input logic r, input logic [15:0] w, input logic [15:0] p,
                        input logic [15:0] b, input logic [15:0] rd, input logic c,
                        input string tag);
        logic [18:0] exp;
        @(posedge clk);
        #1;
        rst_n = r; ir = w; pc = p; base = b; rdata = rd; cap = c;
        @(negedge clk);
        exp = model(w, p, b);
        tests++;
        if ({mode, addr} !== exp) begin
            fails++;
            $display("FAIL %s: mode=%0d addr=%04h expected mode=%0d addr=%04h",
                     tag, mode, addr, exp[18:16], exp[15:0]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] ldi_a;
        ldi_a = i9(10, 10);
        // R10 reset state
        step(0, ldi_a, 16'h3000, 0, 0, 0, "R10 in reset");
        step(0, ldi_a, 16'h3000, 0, 0, 0, "R10 in reset");
        step(1, ldi_a, 16'h3000, 0, 0, 0, "R10 after reset");
        // R1 / R11 PC-relative
        step(1, i9(2, 255),  16'h3000, 0, 0, 0, "R1 R11 LD +255");
        step(1, i9(14, -256),16'h3000, 0, 0, 0, "R1 R11 LEA -256");
        step(1, i9(0, 5),    16'h3000, 0, 0, 0, "R1 BR");
        step(1, i9(3, -1),   16'h4000, 0, 0, 0, "R1 ST");
        // R2 / R11 base offset
        step(1, i6(6, -32), 0, 16'h4000, 0, 0, "R2 R11 LDR -32");
        step(1, i6(7, 31),  0, 16'h4000, 0, 0, "R2 R11 STR +31");
        // R9 wrap
        step(1, i9(2, 255),  16'hFFF0, 0, 0, 0, "R9 wrap up");
        step(1, i9(0, -256), 16'h0005, 0, 0, 0, "R9 wrap down");
        step(1, i6(6, 31),   0, 16'hFFFF, 0, 0, "R9 base wrap");
        // R3 jump
        step(1, 16'hC080, 0, 16'h1234, 0, 0, "R3 JMP valid");
        step(1, 16'hC081, 0, 16'h1234, 0, 0, "R3 JMP bad low");
        step(1, 16'hC280, 0, 16'h1234, 0, 0, "R3 JMP bad high");
        // R4 other opcodes
        step(1, 16'h1261, 16'h3000, 16'h1111, 0, 0, "R4 ADD");
        step(1, 16'hF025, 16'h3000, 16'h1111, 0, 0, "R4 TRAP");
        step(1, 16'h927F, 16'h3000, 16'h1111, 0, 0, "R4 NOT");
        // R5 / R6 indirect
        step(1, ldi_a, 16'h3000, 0, 16'hABCD, 1, "R5 pointer fetch");
        step(1, ldi_a, 16'h3000, 0, 16'h0000, 0, "R6 final");
        // R7 strobe on non-indirect ignored, hold without strobe
        step(1, i9(2, 3), 16'h3000, 0, 16'h5555, 1, "R7 LD with strobe");
        step(1, ldi_a, 16'h3000, 0, 16'h7777, 0, "R7 pointer kept");
        step(1, ldi_a, 16'h3000, 0, 16'h8888, 0, "R7 hold");
        // R8 pointer bound to word
        step(1, i9(10, 11), 16'h3000, 0, 0, 0, "R8 other LDI");
        step(1, i9(11, 10), 16'h3000, 0, 0, 0, "R8 STI same offset");
        step(1, ldi_a, 16'h3000, 0, 0, 0, "R8 original back");
        step(1, i9(11, -20), 16'h3000, 0, 16'h2468, 1, "R6 STI capture");
        step(1, i9(11, -20), 16'h3000, 0, 0, 0, "R6 STI final");
        step(1, ldi_a, 16'h3000, 0, 0, 0, "R8 replaced");
        // R10 reset discards
        step(0, ldi_a, 16'h3000, 0, 0, 0, "R10 reset");
        step(1, i9(11, -20), 16'h3000, 0, 0, 0, "R10 pointer dropped");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule